// File: doc/BRIEF.md
# Masked-Write GPIO Port Bank

This block is a bank of general-purpose I/O ports on a simple 32-bit memory-mapped bus. Each port groups a parameterised number of pins. For every port it holds three writable registers and one read-only register. The mode register selects whether a pin is under GPIO control. The drive-enable register turns on the pad driver. The level register sets the value driven onto the pad. The input register reports the synchronised pad level.

Each writable register can also be reached at a second address, its masked alias. A write there carries a per-bit write enable in bits [15:8] and the new values in bits [7:0]. Software can then change single pins without a read-modify-write sequence, so two agents that own different pins of one port cannot overwrite each other's bits.

The pad driver is on only when both the mode bit and the drive-enable bit of a pin are set. To turn a pin into an output without a glitch, software writes the level first, then the drive enable, then the mode bit.

Top module: `gpb_port_bank`

## Requirements
- R1: After reset every mode, drive-enable and level register is 0, so pad_oe, pad_out and pin_gpio_en are all 0 and bus_rdata is 0.
- R2: A plain write stores bus_wdata[7:0] in the addressed register. The byte address is group*0x10 + port*4, with group 0 = mode, 1 = drive enable, 2 = level and 3 = input. A read of that address afterwards returns the stored value.
- R3: A write to the masked alias (plain address + 0x80) changes only the bits whose enable bit in bus_wdata[15:8] is 1. Each such bit takes the matching bit of bus_wdata[7:0], and every other bit keeps its value.
- R4: A masked-alias write whose enable byte is zero leaves every register unchanged.
- R5: The input group (offset 0x30) returns the port's synchronised pad levels in bits [7:0], and writes to it, plain or aliased, have no effect.
- R6: A pad level change is visible to a read issued two clock edges after the change, and not to a read issued one edge after it (two-flop synchroniser).
- R7: pad_oe of a pin is 1 exactly when both its mode bit and its drive-enable bit are 1. pad_out follows the level bit and pin_gpio_en follows the mode bit. Pin index = port*8 + bit.
- R8: A read of a masked-alias address returns the plain register value in bits [7:0], and every read returns zero in bits [31:8].
- R9: Read data is registered and appears on bus_rdata on the edge that samples the read. It holds its value when no read is sampled.
- R10: Accesses to an address with a bit set outside the group, port and alias fields (for example 0x40) write nothing and read zero.
- R11: Writing level, then drive enable, then mode for one pin keeps that pin's pad_oe at 0 until the mode write. When pad_oe rises, pad_out already carries the written level, and no other pin's outputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data; [15:8] masks and [7:0] values on alias writes |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PORTS*PINS (32) | Raw pad levels |
| pad_out | output | NUM_PORTS*PINS (32) | Pad drive values |
| pad_oe | output | NUM_PORTS*PINS (32) | Pad driver enables |
| pin_gpio_en | output | NUM_PORTS*PINS (32) | Per-pin GPIO mode select for the pin multiplexer |

## Verification
The bench builds the block with four ports of eight pins, an 8-bit address and the alias offset at 0x80. With these values every group, port and alias combination can be reached, and so can an unmapped address bit (bit 6). Random plain and masked writes mix with reads and pad changes. Directed cases cover the synchroniser latency edge, a zero enable byte, writes to the input group and the level, drive-enable, mode bring-up order.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
   localparam int MAX_PORTS = 4;
   localparam int NUM_WGROUPS = 3;
   typedef enum logic [1:0] {
      GRP_MODE  = 2'd0,
      GRP_DRIVE = 2'd1,
      GRP_LEVEL = 2'd2,
      GRP_INPUT = 2'd3
   } gpb_grp_e;
endpackage

// File: rtl/gpb_decode.sv
module gpb_decode
   import gpb_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int NUM_PORTS = 4,
   parameter int ALIAS_OFS = 'h80
) (
   input  logic [ADDR_W-1:0] addr,
   output gpb_grp_e          grp,
   output logic [1:0]        port_idx,
   output logic              is_alias,
   output logic              in_range
);
   localparam int ALIAS_BIT = $clog2(ALIAS_OFS);
   localparam logic [ADDR_W-1:0] KNOWN = ADDR_W'('h3F) | ADDR_W'(ALIAS_OFS);

   always_comb begin
      grp      = gpb_grp_e'(addr[5:4]);
      port_idx = addr[3:2];
      is_alias = addr[ALIAS_BIT];
      in_range = ((addr & ~KNOWN) == '0) && (32'(port_idx) < NUM_PORTS);
   end
endmodule

// File: rtl/gpb_mreg.sv
module gpb_mreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         masked,
   input  logic [W-1:0] wval,
   input  logic [W-1:0] wmask,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (wr_en)
         q <= masked ? ((q & ~wmask) | (wval & wmask)) : wval;
   end
endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/gpb_port_bank.sv
module gpb_port_bank
   import gpb_pkg::*;
#(
   parameter int NUM_PORTS   = 4,
   parameter int PINS        = 8,
   parameter int ADDR_W      = 8,
   parameter int ALIAS_OFS   = 'h80,
   parameter int SYNC_STAGES = 2,
   localparam int NPINS      = NUM_PORTS * PINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pin_gpio_en
);
   localparam int ALIAS_BIT = $clog2(ALIAS_OFS);

   // elaboration-time parameter checks
   if (NUM_PORTS < 1 || NUM_PORTS > MAX_PORTS) begin : g_bad_ports
      $error("NUM_PORTS must be 1..4");
   end
   if (PINS < 1 || PINS > 8) begin : g_bad_pins
      $error("PINS must be 1..8");
   end
   if ((ALIAS_OFS & (ALIAS_OFS - 1)) != 0 || ALIAS_OFS < 'h40) begin : g_bad_alias
      $error("ALIAS_OFS must be a power of two of at least 0x40");
   end
   if (ALIAS_BIT >= ADDR_W) begin : g_bad_aw
      $error("ALIAS_OFS does not fit in ADDR_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   gpb_grp_e   grp;
   logic [1:0] port_idx;
   logic       is_alias;
   logic       in_range;

   gpb_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_PORTS(NUM_PORTS),
      .ALIAS_OFS(ALIAS_OFS)
   ) u_dec (
      .addr    (bus_addr),
      .grp     (grp),
      .port_idx(port_idx),
      .is_alias(is_alias),
      .in_range(in_range)
   );

   logic [NPINS-1:0] pad_sync;

   gpb_sync #(
      .WIDTH (NPINS),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (pad_sync)
   );

   logic [PINS-1:0] reg_q [NUM_WGROUPS][MAX_PORTS];
   logic [PINS-1:0] in_q  [MAX_PORTS];
   logic            wr_hit;

   assign wr_hit = bus_sel && bus_wr && in_range;

   for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
      if (p < NUM_PORTS) begin : g_live
         for (genvar g = 0; g < NUM_WGROUPS; g++) begin : g_grp
            logic we;
            assign we = wr_hit && (port_idx == 2'(p)) && (grp == gpb_grp_e'(g));
            gpb_mreg #(.W(PINS)) u_reg (
               .clk   (clk),
               .rst_n (rst_n),
               .wr_en (we),
               .masked(is_alias),
               .wval  (bus_wdata[PINS-1:0]),
               .wmask (bus_wdata[8 +: PINS]),
               .q     (reg_q[g][p])
            );
         end
         assign in_q[p] = pad_sync[p*PINS +: PINS];
         assign pin_gpio_en[p*PINS +: PINS] = reg_q[GRP_MODE][p];
         assign pad_oe[p*PINS +: PINS]      = reg_q[GRP_MODE][p] & reg_q[GRP_DRIVE][p];
         assign pad_out[p*PINS +: PINS]     = reg_q[GRP_LEVEL][p];
      end else begin : g_tie
         for (genvar g = 0; g < NUM_WGROUPS; g++) begin : g_grp
            assign reg_q[g][p] = '0;
         end
         assign in_q[p] = '0;
      end
   end

   logic [PINS-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (in_range) begin
         case (grp)
            GRP_MODE:  rd_val = reg_q[GRP_MODE][port_idx];
            GRP_DRIVE: rd_val = reg_q[GRP_DRIVE][port_idx];
            GRP_LEVEL: rd_val = reg_q[GRP_LEVEL][port_idx];
            default:   rd_val = in_q[port_idx];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_sel && !bus_wr)
         bus_rdata <= {{(32 - PINS){1'b0}}, rd_val};
   end
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker #(
   parameter int ADDR_W    = 8,
   parameter int PINS      = 8,
   parameter int NPINS     = 32,
   parameter int ALIAS_BIT = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [NPINS-1:0]  pad_out,
   input logic [NPINS-1:0]  pad_oe,
   input logic [NPINS-1:0]  pin_gpio_en
);
   p_reset_state_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && pin_gpio_en == '0 && bus_rdata == '0));

   p_mask_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_sel && bus_wr && bus_addr[ALIAS_BIT] && bus_wdata[8 +: PINS] == '0)
      |-> ($stable(pad_oe) && $stable(pad_out) && $stable(pin_gpio_en)));

   p_oe_needs_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~pin_gpio_en) == '0);

   p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_sel && !bus_wr) |-> bus_rdata[31:8] == '0);

   p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_sel && !bus_wr) |-> $stable(bus_rdata));

   p_no_write_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_sel && bus_wr) |-> ($stable(pad_oe) && $stable(pad_out) && $stable(pin_gpio_en)));
endmodule

bind gpb_port_bank gpb_checker #(
   .ADDR_W   (ADDR_W),
   .PINS     (PINS),
   .NPINS    (NPINS),
   .ALIAS_BIT(ALIAS_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .pad_out    (pad_out),
   .pad_oe     (pad_oe),
   .pin_gpio_en(pin_gpio_en)
);

// File: tb/gpb_port_bank_test.sv
module gpb_port_bank_test;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int PW = 8;
   localparam int NPINS = NP * PW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0;
   logic              bus_wr = 1'b0;
   logic [7:0]        bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NPINS-1:0]  pad_in = '0;
   logic [NPINS-1:0]  pad_out;
   logic [NPINS-1:0]  pad_oe;
   logic [NPINS-1:0]  pin_gpio_en;

   int checks = 0;
   int errors = 0;
   int stable_cnt = 0;

   logic [7:0] m_reg [3][NP];

   always #(CLK_PERIOD / 2) clk = ~clk;

   gpb_port_bank uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .pad_in     (pad_in),
      .pad_out    (pad_out),
      .pad_oe     (pad_oe),
      .pin_gpio_en(pin_gpio_en)
   );

   function automatic logic [7:0] f_addr(int grp, int port, bit alias_sel);
      return {alias_sel, 1'b0, 2'(grp), 2'(port), 2'b00};
   endfunction

   function automatic logic [31:0] f_exp_read(logic [7:0] a);
      if (a[6]) return '0;
      if (a[5:4] == 2'd3) return {24'b0, pad_in[a[3:2]*PW +: PW]};
      return {24'b0, m_reg[a[5:4]][a[3:2]]};
   endfunction

   function automatic logic [NPINS-1:0] f_vec(int sel);
      logic [NPINS-1:0] v = '0;
      for (int p = 0; p < NP; p++) begin
         if (sel == 0) v[p*PW +: PW] = m_reg[0][p] & m_reg[1][p];
         else if (sel == 1) v[p*PW +: PW] = m_reg[2][p];
         else v[p*PW +: PW] = m_reg[0][p];
      end
      return v;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_pads(string req);
      chk(req, pad_oe, f_vec(0));
      chk(req, pad_out, f_vec(1));
      chk(req, pin_gpio_en, f_vec(2));
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      stable_cnt++;
      if (!a[6] && a[5:4] != 2'd3) begin
         if (a[7])
            m_reg[a[5:4]][a[3:2]] = (m_reg[a[5:4]][a[3:2]] & ~d[15:8]) | (d[7:0] & d[15:8]);
         else
            m_reg[a[5:4]][a[3:2]] = d[7:0];
      end
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      stable_cnt++;
      chk(req, bus_rdata, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int g = 0; g < 3; g++)
         for (int p = 0; p < NP; p++) m_reg[g][p] = '0;
      repeat (3) @(negedge clk);
      chk("R1", bus_rdata, 32'h0);
      chk_pads("R1");
      rst_n = 1'b1;
      @(negedge clk);
      rd(f_addr(0, 0, 0), 32'h0, "R1");

      // R2 plain write and readback
      wr(f_addr(0, 1, 0), 32'hFFFF_00A5);
      rd(f_addr(0, 1, 0), 32'h0000_00A5, "R2");
      chk_pads("R2");

      // R3 masked update
      wr(f_addr(2, 2, 0), 32'h0000_00F0);
      wr(f_addr(2, 2, 1), 32'h0000_3C14);
      rd(f_addr(2, 2, 0), 32'h0000_00D4, "R3");
      chk_pads("R3");

      // R4 zero enable byte
      wr(f_addr(2, 2, 1), 32'h0000_00FF);
      rd(f_addr(2, 2, 0), 32'h0000_00D4, "R4");
      chk_pads("R4");

      // R8 alias read
      rd(f_addr(2, 2, 1), 32'h0000_00D4, "R8");

      // R5 input group ignores writes
      pad_in = 32'h5A3C_9612;
      repeat (3) @(negedge clk);
      wr(f_addr(3, 1, 0), 32'hFFFF_FFFF);
      wr(f_addr(3, 1, 1), 32'hFFFF_FFFF);
      chk_pads("R5");
      rd(f_addr(3, 1, 0), 32'h0000_0096, "R5");
      rd(f_addr(3, 3, 1), 32'h0000_005A, "R5");

      // R6 synchroniser latency
      pad_in[7:0] = 8'hC3;
      @(negedge clk);
      rd(f_addr(3, 0, 0), 32'h0000_0012, "R6");
      rd(f_addr(3, 0, 0), 32'h0000_00C3, "R6");

      // R11 bring-up order, port 3 pin 5
      wr(f_addr(2, 3, 1), 32'h0000_2020);
      chk("R11", pad_oe[29], 1'b0);
      wr(f_addr(1, 3, 1), 32'h0000_2020);
      chk("R11", pad_oe[29], 1'b0);
      wr(f_addr(0, 3, 1), 32'h0000_2020);
      chk("R11", pad_oe[29], 1'b1);
      chk("R11", pad_out[29], 1'b1);
      chk_pads("R11");
      chk_pads("R7");

      // R10 unmapped address
      wr(8'h44, 32'h0000_FFFF);
      chk_pads("R10");
      rd(8'h44, 32'h0, "R10");

      // random mix
      stable_cnt = 0;
      for (int n = 0; n < 600; n++) begin
         int op = int'($urandom % 10);
         logic [7:0] a = f_addr(int'($urandom % 4), int'($urandom % 4), 1'($urandom % 2));
         if ($urandom % 16 == 0) a[6] = 1'b1;
         if (op < 1) begin
            pad_in = $urandom;
            stable_cnt = 0;
         end else if (op < 6) begin
            wr(a, $urandom);
            chk_pads(a[7] ? "R3" : "R2");
         end else begin
            if (a[5:4] == 2'd3 && !a[6] && stable_cnt < 2) begin
               bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
               @(negedge clk);
               bus_sel = 1'b0;
               stable_cnt++;
            end else begin
               rd(a, f_exp_read(a), a[7] ? "R8" : "R2");
            end
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule